// File: doc/BRIEF.md
# Programmable Counter Channel with Snapshot Latches

This block is one channel of a programmable interval timer. A 16-bit down-counting element counts on a one-cycle count-enable input, `tick`, and drives a single output line, `out`. Software never touches the element directly. The initial count goes into a two-byte holding register one byte at a time, and the element takes both bytes in one transfer. Reads come from a two-byte snapshot that follows the element until a latch command freezes it.

A control-word write programs the channel. It selects the byte access pattern, one of two counting modes (a one-shot that raises `out` at terminal count, or a periodic rate generator) and binary or four-digit BCD arithmetic. A status command captures a status byte that holds the programmed control bits, the present `out` level and a flag that marks a count not yet transferred. The block sits behind a bus decoder that turns host cycles into the single-cycle strobes below. No two strobes are asserted in the same cycle, and a strobe never coincides with `tick`.

Top module: `ptimer_channel`

## Requirements
- R1: After reset, `out` is high and `rd_data` reads 0.
- R2: The control word is taken from `wr_data[3:0]`. Bits [1:0] give the byte access (0 none, 1 low byte only, 2 high byte only, 3 low byte then high byte). Bit 2 gives the mode (0 terminal-count one-shot, 1 rate generator). Bit 3 selects BCD. A control-word write drives `out` low in mode 0 and high in mode 1, zeroes both holding bytes and drops any pending snapshot or status capture.
- R3: A byte is accepted only if the access pattern includes that byte. A byte outside the pattern stays zero. The count is complete on the final byte of the pattern, and the whole 16-bit value enters the element on the next `tick`.
- R4: The null-count flag (status bit 6) is set by a control-word write or a completed count. It is cleared when the holding register is transferred into the element.
- R5: In mode 0, `out` stays low after the load and rises on the Nth `tick` after the load tick. Ticks with `gate` low leave the count unchanged.
- R6: In mode 1, the count repeats with period N ticks. `out` is low for exactly the one tick interval in which the count equals 1, and the next tick reloads N.
- R7: In mode 1, `gate` low forces `out` high in the next cycle and suspends counting. The first `tick` with `gate` high reloads the full count.
- R8: An initial count of 0 behaves as 65536 ticks in binary and as 10000 ticks in BCD. One tick after loading 0, the count reads 0xFFFF in binary or 0x9999 in BCD.
- R9: In BCD each nibble is a decimal digit, and a decrement borrows across digits (0x0010 becomes 0x0009).
- R10: When no snapshot is held, reads show the live count. `cnt_latch` freezes the snapshot until all bytes of the access pattern have been read. Further latch commands while a snapshot is held are ignored.
- R11: Access 1 reads the low byte and access 2 reads the high byte. Access 3 reads low then high, and each `rd_stb` advances to the next byte.
- R12: `stat_latch` captures {out, null-count, 2'b00, control[3:0]}. A captured status byte is read before any count byte, is consumed by one `rd_stb`, and is unaffected by further status commands until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One counting edge per cycle high |
| gate | input | 1 | Count enable / restart input |
| wr_data | input | 8 | Write data for count bytes and control word |
| wr_lo | input | 1 | Strobe: write low count byte |
| wr_hi | input | 1 | Strobe: write high count byte |
| cw_wr | input | 1 | Strobe: write control word |
| cnt_latch | input | 1 | Strobe: freeze count snapshot |
| stat_latch | input | 1 | Strobe: capture status byte |
| rd_stb | input | 1 | Strobe: consume the byte on rd_data |
| rd_data | output | 8 | Read byte (status or count) |
| out | output | 1 | Channel output |

## Verification
On every cycle the embedded assertions check these invariants: an unused high byte stays zero, the null flag clears after a transfer, a mode-0 rising edge happens only at count zero, the count is frozen while gate is low, a mode-1 low output happens only at count one, gate low forces the output high, and a held snapshot or status byte stays stable. The exact tick on which `out` moves, the BCD borrow chain, the wrap of a zero count to its maximum, the byte read order and the status-before-count priority can only be shown by the bench scenarios. A behavioural reference model compares `out` and `rd_data` on every clock.

// File: rtl/ptc_pkg.sv
// Shared types for the counter channel: control-word layout and enums.
// Assumes the control word lives in the low CTRL_W bits of the write bus.
package ptc_pkg;
    typedef enum logic {
        MODE_TERM = 1'b0,
        MODE_RATE = 1'b1
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_BOTH = 2'd3
    } acc_e;

    typedef struct packed {
        logic      bcd;
        cnt_mode_e mode;
        acc_e      acc;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ptc_count_reg.sv
// Two-byte holding register for the initial count plus the null-count flag.
// Accepts only the bytes named by the access pattern and signals completion
// of a count. Assumes cw_wr is never asserted together with a byte strobe.
module ptc_count_reg
    import ptc_pkg::*;
#(
    parameter  int CNT_W  = 16,
    localparam int BYTE_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_wr,
    input  acc_e              acc_q,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              xfer,
    output logic [CNT_W-1:0]  cr_q,
    output logic              cnt_done,
    output logic              nc_q
);
    logic lo_seen_q;
    logic lo_en, hi_en;

    // Byte enables filtered by the programmed access pattern, and count completion.
    always_comb begin
        lo_en    = wr_lo && (acc_q == ACC_LO || acc_q == ACC_BOTH);
        hi_en    = wr_hi && (acc_q == ACC_HI || acc_q == ACC_BOTH);
        cnt_done = !cw_wr && ((lo_en && acc_q == ACC_LO) ||
                              (hi_en && acc_q == ACC_HI) ||
                              (hi_en && acc_q == ACC_BOTH && lo_seen_q));
    end

    // Holding bytes, low-byte-seen marker and null-count flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q      <= '0;
            lo_seen_q <= 1'b0;
            nc_q      <= 1'b0;
        end else if (cw_wr) begin
            cr_q      <= '0;
            lo_seen_q <= 1'b0;
            nc_q      <= 1'b1;
        end else begin
            if (lo_en) begin
                cr_q[BYTE_W-1:0] <= wr_data;
                lo_seen_q        <= (acc_q == ACC_BOTH);
            end
            if (hi_en) cr_q[CNT_W-1:BYTE_W] <= wr_data;
            if (cnt_done) lo_seen_q <= 1'b0;
            if (cnt_done) nc_q <= 1'b1;
            else if (xfer) nc_q <= 1'b0;
        end
    end

    a_r3_unused_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == ACC_LO) |-> (cr_q[CNT_W-1:BYTE_W] == '0));

    a_r4_null_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !cnt_done && !cw_wr) |=> !nc_q);
endmodule

// File: rtl/ptc_down_core.sv
// Down-counting element with mode 0 (one-shot) and mode 1 (rate) output logic.
// Counts once per cycle with tick high; binary or BCD decrement chosen by bcd_q.
// Assumes tick never coincides with a control or count-byte strobe.
module ptc_down_core
    import ptc_pkg::*;
#(
    parameter  int CNT_W  = 16,
    localparam int DIGITS = CNT_W / 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             cw_wr,
    input  cnt_mode_e        mode_new,
    input  cnt_mode_e        mode_q,
    input  logic             bcd_q,
    input  logic             cnt_done,
    input  logic [CNT_W-1:0] cr_q,
    output logic [CNT_W-1:0] ce_q,
    output logic             out_q,
    output logic             xfer
);
    logic              armed_q, load_pend_q;
    logic [DIGITS-1:0] borrow;
    logic [CNT_W-1:0]  bcd_dec, dec_val;
    logic              load_go, step_go, reload_go, at_one, at_two;

    assign borrow[0] = 1'b1;

    // Decimal borrow chain, one stage per digit.
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] dig;
        assign dig                = ce_q[4*g +: 4];
        assign bcd_dec[4*g +: 4]  = borrow[g] ? ((dig == 4'd0) ? 4'd9 : dig - 4'd1) : dig;
        if (g < DIGITS - 1) begin : g_borrow
            assign borrow[g+1] = borrow[g] && (dig == 4'd0);
        end
    end

    // Next-count selection and the three tick actions.
    always_comb begin
        dec_val   = bcd_q ? bcd_dec : (ce_q - CNT_W'(1));
        at_one    = (ce_q == CNT_W'(1));
        at_two    = (ce_q == CNT_W'(2));
        load_go   = tick && load_pend_q && (mode_q == MODE_TERM || gate);
        step_go   = tick && armed_q && gate && !load_pend_q;
        reload_go = step_go && (mode_q == MODE_RATE) && at_one;
        xfer      = !cw_wr && (load_go || reload_go);
    end

    // Counting element, output level and load bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q        <= '0;
            out_q       <= 1'b1;
            armed_q     <= 1'b0;
            load_pend_q <= 1'b0;
        end else if (cw_wr) begin
            armed_q     <= 1'b0;
            load_pend_q <= 1'b0;
            out_q       <= (mode_new == MODE_RATE);
        end else begin
            if (load_go) begin
                ce_q        <= cr_q;
                armed_q     <= 1'b1;
                load_pend_q <= 1'b0;
                if (mode_q == MODE_RATE) out_q <= 1'b1;
            end else if (step_go) begin
                if (mode_q == MODE_RATE) begin
                    if (at_one) begin
                        ce_q  <= cr_q;
                        out_q <= 1'b1;
                    end else begin
                        ce_q  <= dec_val;
                        out_q <= !at_two;
                    end
                end else begin
                    ce_q <= dec_val;
                    if (at_one) out_q <= 1'b1;
                end
            end
            if (cnt_done) begin
                load_pend_q <= 1'b1;
                if (mode_q == MODE_TERM) out_q <= 1'b0;
            end
            if (mode_q == MODE_RATE && !gate) begin
                out_q <= 1'b1;
                if (armed_q) load_pend_q <= 1'b1;
            end
        end
    end

    a_r5_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TERM && $rose(out_q)) |-> (ce_q == '0));

    a_r5_gate_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TERM && armed_q && !load_pend_q && !gate && !cw_wr) |=> $stable(ce_q));

    a_r6_low_only_at_one: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RATE && !out_q) |-> (ce_q == CNT_W'(1)));

    a_r7_gate_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RATE && !gate && !cw_wr) |=> out_q);
endmodule

// File: rtl/ptc_readout.sv
// Read path: count snapshot that follows the element until frozen, status
// capture, and byte sequencing onto the read bus. Status has read priority.
// Assumes at most one strobe per cycle.
module ptc_readout
    import ptc_pkg::*;
#(
    parameter  int CNT_W  = 16,
    localparam int BYTE_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_wr,
    input  logic              cnt_latch,
    input  logic              stat_latch,
    input  logic              rd_stb,
    input  acc_e              acc_q,
    input  logic [CNT_W-1:0]  ce_q,
    input  logic [BYTE_W-1:0] status_in,
    output logic [BYTE_W-1:0] rd_data
);
    logic [CNT_W-1:0]  ol_q, view;
    logic [BYTE_W-1:0] st_q;
    logic              frozen_q, st_full_q, hi_next_q, pick_hi, last_byte;

    // Byte selection: status first, else the snapshot or live count.
    always_comb begin
        view      = frozen_q ? ol_q : ce_q;
        pick_hi   = (acc_q == ACC_HI) || (acc_q == ACC_BOTH && hi_next_q);
        last_byte = (acc_q != ACC_BOTH) || hi_next_q;
        rd_data   = st_full_q ? st_q : (pick_hi ? view[BYTE_W +: BYTE_W] : view[0 +: BYTE_W]);
    end

    // Snapshot, status capture and read-sequence state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ol_q      <= '0;
            st_q      <= '0;
            frozen_q  <= 1'b0;
            st_full_q <= 1'b0;
            hi_next_q <= 1'b0;
        end else if (cw_wr) begin
            frozen_q  <= 1'b0;
            st_full_q <= 1'b0;
            hi_next_q <= 1'b0;
        end else begin
            if (rd_stb) begin
                if (st_full_q) st_full_q <= 1'b0;
                else begin
                    if (acc_q == ACC_BOTH) hi_next_q <= !hi_next_q;
                    if (last_byte) frozen_q <= 1'b0;
                end
            end
            if (cnt_latch && !frozen_q) begin
                ol_q     <= ce_q;
                frozen_q <= 1'b1;
            end
            if (stat_latch && !st_full_q) begin
                st_q      <= status_in;
                st_full_q <= 1'b1;
            end
        end
    end

    a_r10_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_q && !rd_stb && !cw_wr) |=> (frozen_q && $stable(ol_q)));

    a_r12_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_full_q && !rd_stb && !cw_wr) |=> (st_full_q && $stable(st_q)));
endmodule

// File: rtl/ptimer_channel.sv
// One programmable timer channel: control register, holding register,
// down-counting core and read path. Assumes strobes are single-cycle,
// mutually exclusive and never in the same cycle as tick.
module ptimer_channel
    import ptc_pkg::*;
#(
    parameter  int CNT_W  = 16,
    localparam int BYTE_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              gate,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              cw_wr,
    input  logic              cnt_latch,
    input  logic              stat_latch,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] rd_data,
    output logic              out
);
    ctrl_t             ctrl_q, ctrl_new;
    logic [CNT_W-1:0]  cr_q, ce_q;
    logic              cnt_done, nc_q, xfer, out_q;
    logic [BYTE_W-1:0] status_byte;

    // Decode the incoming control word and assemble the status byte.
    always_comb begin
        ctrl_new    = ctrl_t'(wr_data[CTRL_W-1:0]);
        status_byte = {out_q, nc_q, {(BYTE_W-2-CTRL_W){1'b0}}, ctrl_q};
        out         = out_q;
    end

    // Programmed control word.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (cw_wr) ctrl_q <= ctrl_new;
    end

    ptc_count_reg #(.CNT_W(CNT_W)) u_cr (
        .clk(clk), .rst_n(rst_n), .cw_wr(cw_wr), .acc_q(ctrl_q.acc),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .xfer(xfer),
        .cr_q(cr_q), .cnt_done(cnt_done), .nc_q(nc_q)
    );

    ptc_down_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .cw_wr(cw_wr),
        .mode_new(ctrl_new.mode), .mode_q(ctrl_q.mode), .bcd_q(ctrl_q.bcd),
        .cnt_done(cnt_done), .cr_q(cr_q), .ce_q(ce_q), .out_q(out_q), .xfer(xfer)
    );

    ptc_readout #(.CNT_W(CNT_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .cw_wr(cw_wr), .cnt_latch(cnt_latch),
        .stat_latch(stat_latch), .rd_stb(rd_stb), .acc_q(ctrl_q.acc),
        .ce_q(ce_q), .status_in(status_byte), .rd_data(rd_data)
    );
endmodule

// File: tb/ptimer_channel_test.sv
// Bench: behavioural reference model compared every clock, plus scenario checks.
module ptimer_channel_test;
    logic       clk = 0, rst_n = 0, tick = 0, gate = 1;
    logic [7:0] wr_data = 0;
    logic       wr_lo = 0, wr_hi = 0, cw_wr = 0, cnt_latch = 0, stat_latch = 0, rd_stb = 0;
    logic [7:0] rd_data;
    logic       out;
    int checks = 0, failures = 0, cyc = 0;
    bit fin = 0;

    ptimer_channel uut (.clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .wr_data(wr_data),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .cw_wr(cw_wr), .cnt_latch(cnt_latch),
        .stat_latch(stat_latch), .rd_stb(rd_stb), .rd_data(rd_data), .out(out));

    always #5 clk = ~clk;

    // Reference model state
    int m_ce, m_cr, m_out, m_nc, m_armed, m_pend, m_loseen, m_acc, m_mode, m_bcd;
    int m_ol, m_frz, m_st, m_stf, m_hin;

    function automatic int mdec(int v, int b);
        int x;
        if (b == 0) return (v + 65535) % 65536;
        x = ((v >> 12) & 15) * 1000 + ((v >> 8) & 15) * 100 + ((v >> 4) & 15) * 10 + (v & 15);
        x = (x + 9999) % 10000;
        return ((x / 1000) << 12) | (((x / 100) % 10) << 8) | (((x / 10) % 10) << 4) | (x % 10);
    endfunction

    function automatic int model_rd();
        int v;
        if (m_stf != 0) return m_st;
        v = (m_frz != 0) ? m_ol : m_ce;
        if (m_acc == 2 || (m_acc == 3 && m_hin != 0)) return (v >> 8) & 255;
        return v & 255;
    endfunction

    always @(posedge clk) begin
        int d, lo_ok, hi_ok, done, xf, n_ce, n_out, n_pend, n_armed, status, ofrz, ostf, last;
        d = int'(wr_data);
        if (!rst_n) begin
            m_ce = 0; m_cr = 0; m_out = 1; m_nc = 0; m_armed = 0; m_pend = 0; m_loseen = 0;
            m_acc = 0; m_mode = 0; m_bcd = 0; m_ol = 0; m_frz = 0; m_st = 0; m_stf = 0; m_hin = 0;
        end else if (cw_wr) begin
            m_acc = d & 3; m_mode = (d >> 2) & 1; m_bcd = (d >> 3) & 1;
            m_cr = 0; m_loseen = 0; m_nc = 1; m_armed = 0; m_pend = 0; m_out = m_mode;
            m_frz = 0; m_stf = 0; m_hin = 0;
        end else begin
            status = m_out * 128 + m_nc * 64 + m_bcd * 8 + m_mode * 4 + m_acc;
            lo_ok = (wr_lo && (m_acc == 1 || m_acc == 3)) ? 1 : 0;
            hi_ok = (wr_hi && (m_acc == 2 || m_acc == 3)) ? 1 : 0;
            done = ((lo_ok != 0 && m_acc == 1) || (hi_ok != 0 && m_acc == 2) ||
                    (hi_ok != 0 && m_acc == 3 && m_loseen != 0)) ? 1 : 0;
            xf = 0; n_ce = m_ce; n_out = m_out; n_pend = m_pend; n_armed = m_armed;
            if (tick && m_pend != 0 && (m_mode == 0 || gate)) begin
                n_ce = m_cr; n_armed = 1; n_pend = 0; xf = 1;
                if (m_mode == 1) n_out = 1;
            end else if (tick && m_armed != 0 && gate && m_pend == 0) begin
                if (m_mode == 1 && m_ce == 1) begin n_ce = m_cr; n_out = 1; xf = 1; end
                else begin
                    n_ce = mdec(m_ce, m_bcd);
                    if (m_mode == 1) n_out = (n_ce == 1) ? 0 : 1;
                    else if (m_ce == 1) n_out = 1;
                end
            end
            if (done != 0) begin n_pend = 1; if (m_mode == 0) n_out = 0; end
            if (m_mode == 1 && !gate) begin n_out = 1; if (m_armed != 0) n_pend = 1; end
            ofrz = m_frz; ostf = m_stf;
            if (rd_stb) begin
                if (ostf != 0) m_stf = 0;
                else begin
                    last = (m_acc != 3 || m_hin != 0) ? 1 : 0;
                    if (m_acc == 3) m_hin = (m_hin != 0) ? 0 : 1;
                    if (last != 0) m_frz = 0;
                end
            end
            if (cnt_latch && ofrz == 0) begin m_ol = m_ce; m_frz = 1; end
            if (stat_latch && ostf == 0) begin m_st = status; m_stf = 1; end
            if (lo_ok != 0) begin m_cr = (m_cr & 'hFF00) | d; m_loseen = (m_acc == 3) ? 1 : 0; end
            if (hi_ok != 0) m_cr = (m_cr & 'h00FF) | (d << 8);
            if (done != 0) m_loseen = 0;
            if (done != 0) m_nc = 1; else if (xf != 0) m_nc = 0;
            m_ce = n_ce; m_out = n_out; m_pend = n_pend; m_armed = n_armed;
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            checks++;
            if (out !== m_out[0] || int'(rd_data) != model_rd()) begin
                failures++;
                $display("FAIL model-compare (all requirements) actual out=%0d rd=%0h expected out=%0d rd=%0h",
                         out, rd_data, m_out, model_rd());
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !fin) begin
            fin = 1;
            failures++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_cw(input int v);
        @(negedge clk); wr_data = 8'(v); cw_wr = 1; @(negedge clk); cw_wr = 0;
    endtask
    task automatic put_lo(input int v);
        @(negedge clk); wr_data = 8'(v); wr_lo = 1; @(negedge clk); wr_lo = 0;
    endtask
    task automatic put_hi(input int v);
        @(negedge clk); wr_data = 8'(v); wr_hi = 1; @(negedge clk); wr_hi = 0;
    endtask
    task automatic do_latch();
        @(negedge clk); cnt_latch = 1; @(negedge clk); cnt_latch = 0;
    endtask
    task automatic do_status();
        @(negedge clk); stat_latch = 1; @(negedge clk); stat_latch = 0;
    endtask
    task automatic rd_byte(output int b);
        @(negedge clk); b = int'(rd_data); rd_stb = 1; @(negedge clk); rd_stb = 0;
    endtask
    task automatic ticks(input int n);
        @(negedge clk); tick = 1; repeat (n) @(negedge clk); tick = 0;
    endtask
    task automatic set_gate(input logic g);
        @(negedge clk); gate = g; @(negedge clk);
    endtask

    initial begin
        int b;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset out", int'(out), 1);
        chk("R1 reset rd_data", int'(rd_data), 0);

        // Mode 0, binary, low-then-high, count 5
        pulse_cw('h03);
        chk("R2 mode0 program drives out low", int'(out), 0);
        put_lo(5); put_hi(0);
        do_status(); rd_byte(b);
        chk("R12 R4 status before load", b, 'h43);
        ticks(1);
        do_status(); rd_byte(b);
        chk("R4 null cleared after transfer", b, 'h03);
        ticks(2); do_latch(); ticks(1);
        rd_byte(b); chk("R10 R11 frozen low byte", b, 3);
        rd_byte(b); chk("R11 frozen high byte", b, 0);
        rd_byte(b); chk("R10 live low byte after release", b, 2);
        rd_byte(b);
        ticks(1); chk("R5 out low at count 1", int'(out), 0);
        ticks(1); chk("R5 out high after N ticks", int'(out), 1);

        // Mode 0 gate suspend, low byte only
        pulse_cw('h01); put_lo(3); ticks(1);
        set_gate(0); ticks(5);
        chk("R5 out low while gated", int'(out), 0);
        rd_byte(b); chk("R5 count frozen by gate", b, 3);
        set_gate(1); ticks(2);
        chk("R5 out low before zero", int'(out), 0);
        ticks(1); chk("R5 out high at zero", int'(out), 1);

        // High byte only: low byte must be zero (was 3 before reprogram)
        pulse_cw('h02); put_hi(1); ticks(1); ticks(255);
        chk("R3 out low after 255 ticks of 0x0100", int'(out), 0);
        rd_byte(b); chk("R11 high-only read", b, 0);
        ticks(1); chk("R3 out high after 256 ticks", int'(out), 1);

        // Mode 1 rate generator, count 4
        pulse_cw('h05);
        chk("R2 mode1 program drives out high", int'(out), 1);
        put_lo(4); ticks(1); ticks(2);
        chk("R6 out high at count 2", int'(out), 1);
        ticks(1); chk("R6 out low at count 1", int'(out), 0);
        ticks(1); chk("R6 out high after reload", int'(out), 1);
        rd_byte(b); chk("R6 reload value", b, 4);
        ticks(1);
        set_gate(0); chk("R7 gate low out high", int'(out), 1);
        ticks(3); rd_byte(b); chk("R7 count held while gated", b, 3);
        set_gate(1); ticks(1);
        rd_byte(b); chk("R7 restart reloads full count", b, 4);
        ticks(3); chk("R6 out low after restart period", int'(out), 0);
        set_gate(0); chk("R7 gate low forces out high from low", int'(out), 1);
        set_gate(1); ticks(1);

        // BCD, count 0x0010
        pulse_cw('h0B); put_lo('h10); put_hi(0); ticks(1); ticks(1);
        rd_byte(b); chk("R9 BCD borrow low byte", b, 'h09);
        rd_byte(b); chk("R9 BCD borrow high byte", b, 'h00);
        ticks(8); chk("R9 out low at BCD count 1", int'(out), 0);
        ticks(1); chk("R9 out high after 10 BCD ticks", int'(out), 1);

        // Binary zero count
        pulse_cw('h03); put_lo(0); put_hi(0); ticks(1); ticks(1);
        rd_byte(b); chk("R8 binary wrap low", b, 'hFF);
        rd_byte(b); chk("R8 binary wrap high", b, 'hFF);
        ticks(65534); chk("R8 out low before 65536", int'(out), 0);
        ticks(1); chk("R8 out high at 65536", int'(out), 1);

        // BCD zero count
        pulse_cw('h0B); put_lo(0); put_hi(0); ticks(1); ticks(1);
        rd_byte(b); chk("R8 BCD wrap low", b, 'h99);
        rd_byte(b); chk("R8 BCD wrap high", b, 'h99);
        ticks(9998); chk("R8 out low before 10000", int'(out), 0);
        ticks(1); chk("R8 out high at 10000", int'(out), 1);

        // Second latch ignored while held
        pulse_cw('h03); put_lo('h34); put_hi('h12); ticks(1);
        do_latch(); ticks(3); do_latch(); ticks(1);
        rd_byte(b); chk("R10 first snapshot low kept", b, 'h34);
        rd_byte(b); chk("R10 first snapshot high kept", b, 'h12);
        do_latch();
        rd_byte(b); chk("R10 new snapshot low", b, 'h30);
        rd_byte(b); chk("R10 new snapshot high", b, 'h12);

        // Status priority over a held count snapshot
        do_status(); do_latch();
        rd_byte(b); chk("R12 status read first", b, 'h03);
        rd_byte(b); chk("R12 count low after status", b, 'h30);
        rd_byte(b); chk("R12 count high after status", b, 'h12);

        repeat (3) @(negedge clk);
        fin = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule